// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a real-time clock peripheral on a flat single-cycle register bus. A one-pulse-per-second tick advances a calendar of seconds, minutes, hours, day of month, month, two-digit year and weekday. Every field is held in packed BCD. The day count follows each month's length and includes a leap rule for February. A software-controlled run bit gates the counting. When the run bit is off, software can rewrite the time fields in a burst without racing the tick.

Software reads the time through a set of shadow latches. Setting a capture bit in the control register copies the live counters into the latches in one edge. After that, all seven time offsets return that stable copy until the next capture. Six alarm fields are compared against the calendar value on every advance.

A status register records the following flags:
- one-second, one-minute, one-hour and one-day roll events
- an alarm match
- a power-up marker

Each flag is cleared by writing 1 to it. A level interrupt combines the alarm flag with one selectable periodic flag under two enable bits. Two compensation bytes are plain storage and only read back what was written.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, year 00, weekday 00. Control and interrupt-enable read 0x00, status reads 0x80 and the interrupt output is low.
- R2: Control bit 0 is the run bit. Each tick advances the calendar by one second only while run is 1. While run is 0 the counters hold. Status bit 1 mirrors the run bit. A time-field write in the same cycle as a tick takes priority and that tick is dropped.
- R3: Seconds and minutes wrap from 59 to 00 and hours from 23 to 00. Each wrap carries into the next field.
- R4: The day wraps to 01 after day 30 in months 4, 6, 9 and 11 and after day 31 in the other months except February. In February it wraps after day 29 when the year's binary value is a multiple of 4, and after day 28 otherwise.
- R5: The month wraps from 12 to 01 and then increments the year. The year wraps from 99 to 00.
- R6: The weekday at offset 0x06 counts 00 to 06 and advances on every day wrap.
- R7: Writing control with bit 6 set copies the live time and weekday into shadow latches. Offsets 0x00–0x06 return the latched copy, never the live count. Bit 6 reads back as 1 in the cycle after that write and as 0 from the next cycle on.
- R8: Status bit 2 sets on every advance. Bit 3 sets on a seconds wrap, bit 4 on a minutes wrap and bit 5 on an hours wrap.
- R9: Status bit 6 sets on an advance whose resulting seconds, minutes, hours, day, month and year all equal alarm offsets 0x07–0x0C respectively.
- R10: Writing status clears each of bits 2–7 written as 1 and leaves bits written as 0 unchanged. Bit 1 is not affected by writes. A flag that sets in the same cycle as its clear stays set.
- R11: Status bit 7 (power-up) is 1 after reset and remains 1 until software clears it.
- R12: Interrupt-enable bits 3:0 are writable. Bits 1:0 choose the periodic flag: 0 = second (status bit 2), 1 = minute (bit 3), 2 = hour (bit 4), 3 = day (bit 5). The irq output is high exactly when (status bit 6 and enable bit 3) or (the chosen periodic flag and enable bit 2).
- R13: The alarm offsets and the compensation offsets 0x10 and 0x11 read back the last byte written. Unmapped offsets read 0x00, and read data is 0x00 while read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| bus_addr_i | input | ADDR_W | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe, acts on the clock edge |
| bus_re_i | input | 1 | Read enable |
| bus_rdata_o | output | 8 | Read data, combinational from offset |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default 5-bit offset width, which covers every mapped register and leaves unmapped offsets such as 0x12 and 0x1F to probe. The tick is a bench-driven pulse rather than a real second. Combined with direct loading of the time fields one second before a boundary, this brings the leap February, the 30-day months and the year-99 wrap within a few cycles each. A behavioural calendar model in plain integers predicts the interrupt level on every clock and the shadow contents after each capture.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int BYTE_W = 8;

  // register offsets (the order of the time fields is visible to software)
  localparam int OFS_WDAY   = 6;
  localparam int OFS_ALM_LO = 7;
  localparam int OFS_ALM_HI = 12;
  localparam int OFS_CTRL   = 13;
  localparam int OFS_STAT   = 14;
  localparam int OFS_IEN    = 15;
  localparam int OFS_CMP_LO = 16;
  localparam int OFS_CMP_HI = 17;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_SNAP = 6;
  localparam int IEN_TMR   = 2;
  localparam int IEN_ALM   = 3;

  // status flag vector (bits 7:2 of the status register)
  localparam int NFLAG   = 6;
  localparam int FL_ALM  = 4;
  localparam int FL_PWR  = 5;

  typedef logic [BYTE_W-1:0] bcd8_t;

  typedef struct packed {
    bcd8_t yr;
    bcd8_t mon;
    bcd8_t day;
    bcd8_t hr;
    bcd8_t mn;
    bcd8_t sec;
  } stamp_t;

  localparam stamp_t STAMP_RST = '{yr: 8'h00, mon: 8'h01, day: 8'h01,
                                   hr: 8'h00, mn: 8'h00, sec: 8'h00};

  function automatic int unsigned bcd_val(bcd8_t b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic bcd8_t bcd_of(int unsigned v);
    bcd8_t r;
    r[7:4] = 4'(v / 10);
    r[3:0] = 4'(v % 10);
    return r;
  endfunction

  // days in the month; leap test on the binary year value
  function automatic int unsigned month_len(bcd8_t mon, bcd8_t yr);
    case (bcd_val(mon))
      4, 6, 9, 11: return 30;
      2:           return (bcd_val(yr) % 4 == 0) ? 29 : 28;
      default:     return 31;
    endcase
  endfunction

  // {wrapped, next value}: wraps to lo once the value reaches hi
  function automatic logic [8:0] bcd_step(bcd8_t v, int unsigned lo, int unsigned hi);
    if (bcd_val(v) >= hi) return {1'b1, bcd_of(lo)};
    return {1'b0, bcd_of(bcd_val(v) + 1)};
  endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       wr_i,
  input  logic [2:0] wr_idx_i,
  input  bcd8_t      wr_val_i,
  output stamp_t     live_o,
  output bcd8_t      wday_o,
  output stamp_t     next_o,
  output logic [3:0] roll_o
);

  stamp_t     live_q, nxt;
  bcd8_t      wd_q, nxt_wd;
  logic [8:0] st_sec, st_min, st_hr, st_day, st_mon, st_yr, st_wd;
  logic       c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    st_sec = bcd_step(live_q.sec, 0, 59);
    st_min = bcd_step(live_q.mn,  0, 59);
    st_hr  = bcd_step(live_q.hr,  0, 23);
    st_day = bcd_step(live_q.day, 1, month_len(live_q.mon, live_q.yr));
    st_mon = bcd_step(live_q.mon, 1, 12);
    st_yr  = bcd_step(live_q.yr,  0, 99);
    st_wd  = bcd_step(wd_q,       0, 6);

    c_min = st_sec[8];
    c_hr  = c_min & st_min[8];
    c_day = c_hr  & st_hr[8];
    c_mon = c_day & st_day[8];
    c_yr  = c_mon & st_mon[8];

    nxt.sec = st_sec[7:0];
    nxt.mn  = c_min ? st_min[7:0] : live_q.mn;
    nxt.hr  = c_hr  ? st_hr[7:0]  : live_q.hr;
    nxt.day = c_day ? st_day[7:0] : live_q.day;
    nxt.mon = c_mon ? st_mon[7:0] : live_q.mon;
    nxt.yr  = c_yr  ? st_yr[7:0]  : live_q.yr;
    nxt_wd  = c_day ? st_wd[7:0]  : wd_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= STAMP_RST;
      wd_q   <= '0;
    end else if (wr_i) begin
      case (wr_idx_i)
        3'd0:    live_q.sec <= wr_val_i;
        3'd1:    live_q.mn  <= wr_val_i;
        3'd2:    live_q.hr  <= wr_val_i;
        3'd3:    live_q.day <= wr_val_i;
        3'd4:    live_q.mon <= wr_val_i;
        3'd5:    live_q.yr  <= wr_val_i;
        default: wd_q       <= wr_val_i;
      endcase
    end else if (adv_i) begin
      live_q <= nxt;
      wd_q   <= nxt_wd;
    end
  end

  assign live_o = live_q;
  assign wday_o = wd_q;
  assign next_o = nxt;
  assign roll_o = {4{adv_i}} & {c_day, c_hr, c_min, 1'b1};

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
#(
  parameter int NFIELD = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] wr_idx_i,
  input  bcd8_t      wr_val_i,
  input  logic       adv_i,
  input  stamp_t     cand_i,
  output stamp_t     alarm_o,
  output logic       hit_o
);

  logic [NFIELD-1:0] match;

  for (genvar k = 0; k < NFIELD; k++) begin : g_fld
    bcd8_t fld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         fld_q <= '0;
      else if (wr_i && wr_idx_i == 3'(k))  fld_q <= wr_val_i;
    end
    assign alarm_o[BYTE_W*k +: BYTE_W] = fld_q;
    assign match[k] = (fld_q == cand_i[BYTE_W*k +: BYTE_W]);
  end

  assign hit_o = adv_i & (&match);

endmodule

// File: rtl/rtc_flags.sv
module rtc_flags #(
  parameter int NF      = 6,
  parameter int PWR_BIT = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flags_o
);

  for (genvar k = 0; k < NF; k++) begin : g_flag
    localparam logic RST_V = (k == PWR_BIT);
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= RST_V;
      else         bit_q <= set_i[k] | (bit_q & ~clr_i[k]);
    end
    assign flags_o[k] = bit_q;
  end

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  output logic [7:0]        bus_rdata_o,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] O_WDAY   = ADDR_W'(OFS_WDAY);
  localparam logic [ADDR_W-1:0] O_ALM_LO = ADDR_W'(OFS_ALM_LO);
  localparam logic [ADDR_W-1:0] O_ALM_HI = ADDR_W'(OFS_ALM_HI);
  localparam logic [ADDR_W-1:0] O_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] O_STAT   = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] O_IEN    = ADDR_W'(OFS_IEN);
  localparam logic [ADDR_W-1:0] O_CMP_LO = ADDR_W'(OFS_CMP_LO);
  localparam logic [ADDR_W-1:0] O_CMP_HI = ADDR_W'(OFS_CMP_HI);
  localparam int SHD_W = 7 * BYTE_W;

  // decode
  logic       time_wr, alm_sel, alm_wr, snap_wr, stat_we;
  logic [2:0] alm_idx;
  assign time_wr = bus_we_i && (bus_addr_i <= O_WDAY);
  assign alm_sel = (bus_addr_i >= O_ALM_LO) && (bus_addr_i <= O_ALM_HI);
  assign alm_wr  = bus_we_i && alm_sel;
  assign alm_idx = 3'(bus_addr_i - O_ALM_LO);
  assign snap_wr = bus_we_i && (bus_addr_i == O_CTRL) && bus_wdata_i[CTRL_SNAP];
  assign stat_we = bus_we_i && (bus_addr_i == O_STAT);

  // registers owned by the top
  logic [7:0]       ctrl_q, cmp_lo_q, cmp_hi_q;
  logic [3:0]       ien_q;
  logic [SHD_W-1:0] shd_q;

  // named internal events
  logic             adv;
  stamp_t           live, nxt, alm_q;
  bcd8_t            wday;
  logic [3:0]       roll;
  logic             alm_hit;
  logic [NFLAG-1:0] flags, fl_set, fl_clr;
  logic             ev_sel;

  assign adv = tick_i && ctrl_q[CTRL_RUN] && !time_wr;

  rtc_calendar u_cal (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (adv),
    .wr_i     (time_wr),
    .wr_idx_i (bus_addr_i[2:0]),
    .wr_val_i (bus_wdata_i),
    .live_o   (live),
    .wday_o   (wday),
    .next_o   (nxt),
    .roll_o   (roll)
  );

  rtc_alarm #(.NFIELD(6)) u_alm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (alm_wr),
    .wr_idx_i (alm_idx),
    .wr_val_i (bus_wdata_i),
    .adv_i    (adv),
    .cand_i   (nxt),
    .alarm_o  (alm_q),
    .hit_o    (alm_hit)
  );

  assign fl_set = {1'b0, alm_hit, roll};
  assign fl_clr = stat_we ? bus_wdata_i[7:2] : '0;

  rtc_flags #(.NF(NFLAG), .PWR_BIT(FL_PWR)) u_flg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (fl_set),
    .clr_i   (fl_clr),
    .flags_o (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      ien_q    <= '0;
      cmp_lo_q <= '0;
      cmp_hi_q <= '0;
      shd_q    <= {8'h00, STAMP_RST};
    end else begin
      if (bus_we_i && bus_addr_i == O_CTRL) ctrl_q <= bus_wdata_i;
      else                                   ctrl_q[CTRL_SNAP] <= 1'b0;
      if (snap_wr) shd_q <= {wday, live};
      if (bus_we_i && bus_addr_i == O_IEN)    ien_q    <= bus_wdata_i[3:0];
      if (bus_we_i && bus_addr_i == O_CMP_LO) cmp_lo_q <= bus_wdata_i;
      if (bus_we_i && bus_addr_i == O_CMP_HI) cmp_hi_q <= bus_wdata_i;
    end
  end

  // read path
  always_comb begin
    bus_rdata_o = '0;
    if (bus_re_i) begin
      if (bus_addr_i <= O_WDAY)
        bus_rdata_o = shd_q[{bus_addr_i[2:0], 3'b000} +: BYTE_W];
      else if (alm_sel)
        bus_rdata_o = alm_q[{alm_idx, 3'b000} +: BYTE_W];
      else begin
        case (bus_addr_i)
          O_CTRL:   bus_rdata_o = ctrl_q;
          O_STAT:   bus_rdata_o = {flags, ctrl_q[CTRL_RUN], 1'b0};
          O_IEN:    bus_rdata_o = {4'b0000, ien_q};
          O_CMP_LO: bus_rdata_o = cmp_lo_q;
          O_CMP_HI: bus_rdata_o = cmp_hi_q;
          default:  bus_rdata_o = '0;
        endcase
      end
    end
  end

  // interrupt level
  assign ev_sel = flags[ien_q[1:0]];
  assign irq_o  = (flags[FL_ALM] & ien_q[IEN_ALM]) | (ev_sel & ien_q[IEN_TMR]);

endmodule

// File: rtl/rtc_chk.sv
module rtc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        adv,
  input logic        time_wr,
  input logic        snap_q,
  input logic        snap_wr,
  input logic [47:0] live,
  input logic [5:0]  flags,
  input logic [3:0]  ien,
  input logic        stat_we,
  input logic [7:0]  stat_wd,
  input logic        irq
);

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !time_wr) |=> $stable(live)); // R2

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && live[7:0] == 8'h59) |=> (live[7:0] == 8'h00)); // R3

  AST_SNAP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_q && !snap_wr) |=> !snap_q); // R7

  AST_SEC_EVT_ON_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(adv)); // R8

  AST_ALARM_ON_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[4]) |-> $past(adv)); // R9

  AST_PWR_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[5]) |-> $past(stat_we && stat_wd[7])); // R10

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien[3] || ien[2])); // R12

endmodule

bind bcd_rtc rtc_chk u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .adv     (adv),
  .time_wr (time_wr),
  .snap_q  (ctrl_q[6]),
  .snap_wr (snap_wr),
  .live    (live),
  .flags   (flags),
  .ien     (ien_q),
  .stat_we (stat_we),
  .stat_wd (bus_wdata_i),
  .irq     (irq_o)
);

// File: tb/sim_bcd_rtc.sv
module sim_bcd_rtc;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  bcd_rtc #(.ADDR_W(5)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_we_i    (bus_we),
    .bus_re_i    (bus_re),
    .bus_rdata_o (bus_rdata),
    .irq_o       (irq)
  );

  // ---------------- reference model (binary integers) ----------------
  int         m_t[7];     // sec, min, hour, day, month, year, weekday
  logic [7:0] m_shd[7];
  logic [7:0] m_alm[6];
  logic [7:0] m_ctrl, m_cl, m_ch;
  logic [3:0] m_ien;
  logic [5:0] m_fl;
  int         mdays[12] = '{31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31};

  function automatic logic [7:0] to_bcd(int v);
    return 8'(v + 6 * (v / 10));
  endfunction

  function automatic int from_bcd(logic [7:0] w);
    return int'(w) - 6 * int'(w[7:4]);
  endfunction

  task automatic model_reset();
    m_t = '{0, 0, 0, 1, 1, 0, 0};
    for (int k = 0; k < 7; k++) m_shd[k] = to_bcd(m_t[k]);
    for (int k = 0; k < 6; k++) m_alm[k] = 8'h00;
    m_ctrl = 8'h00; m_cl = 8'h00; m_ch = 8'h00; m_ien = 4'h0;
    m_fl = 6'b100000;
  endtask

  task automatic model_edge(bit we, int a, logic [7:0] wd, bit tk);
    bit         adv;
    logic [5:0] ev;
    int         lim;
    bit         hit;
    adv = tk && m_ctrl[0];
    ev = '0;
    if (we && a == 13 && wd[6])
      for (int k = 0; k < 7; k++) m_shd[k] = to_bcd(m_t[k]);
    if (we && a <= 6) m_t[a] = from_bcd(wd);
    else if (adv) begin
      ev[0] = 1'b1;
      m_t[0]++;
      if (m_t[0] == 60) begin
        m_t[0] = 0; ev[1] = 1'b1; m_t[1]++;
        if (m_t[1] == 60) begin
          m_t[1] = 0; ev[2] = 1'b1; m_t[2]++;
          if (m_t[2] == 24) begin
            m_t[2] = 0; ev[3] = 1'b1;
            m_t[6] = (m_t[6] + 1) % 7;
            m_t[3]++;
            lim = mdays[m_t[4] - 1] + ((m_t[4] == 2 && m_t[5] % 4 == 0) ? 1 : 0);
            if (m_t[3] > lim) begin
              m_t[3] = 1; m_t[4]++;
              if (m_t[4] > 12) begin m_t[4] = 1; m_t[5] = (m_t[5] + 1) % 100; end
            end
          end
        end
      end
      hit = 1'b1;
      for (int k = 0; k < 6; k++) if (to_bcd(m_t[k]) != m_alm[k]) hit = 1'b0;
      ev[4] = hit;
    end
    if (we && a >= 7 && a <= 12) m_alm[a - 7] = wd;
    if (we && a == 13) m_ctrl = wd; else m_ctrl[6] = 1'b0;
    if (we && a == 14) m_fl = m_fl & ~wd[7:2];
    m_fl = m_fl | ev;
    if (we && a == 15) m_ien = wd[3:0];
    if (we && a == 16) m_cl = wd;
    if (we && a == 17) m_ch = wd;
  endtask

  function automatic logic exp_irq();
    return (m_fl[4] & m_ien[3]) | (m_fl[m_ien[1:0]] & m_ien[2]);
  endfunction

  // ---------------- checking ----------------
  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one bus cycle; the model follows the edge, irq compared every clock
  task automatic cyc(bit we, int a, logic [7:0] wd, bit tk);
    bus_we = we; bus_addr = 5'(a); bus_wdata = wd; tick = tk;
    @(posedge clk);
    model_edge(we, a, wd, tk);
    @(negedge clk);
    bus_we = 1'b0; tick = 1'b0;
    chk("R12 irq level", {7'b0, irq}, {7'b0, exp_irq()});
  endtask

  task automatic wr(int a, logic [7:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 0, 8'h00, 1'b1);
  endtask

  task automatic rd(int a, logic [7:0] exp, string tag);
    bus_re = 1'b1; bus_addr = 5'(a);
    #1;
    chk(tag, bus_rdata, exp);
    bus_re = 1'b0;
  endtask

  function automatic logic [7:0] exp_stat();
    return {m_fl, m_ctrl[0], 1'b0};
  endfunction

  task automatic snap_check(string tag);
    wr(13, {m_ctrl[7], 1'b1, m_ctrl[5:0]});
    for (int k = 0; k < 7; k++) rd(k, m_shd[k], tag);
  endtask

  task automatic load_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                           logic [7:0] d, logic [7:0] mo, logic [7:0] y);
    wr(0, s); wr(1, mi); wr(2, h); wr(3, d); wr(4, mo); wr(5, y);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R11 reset state
    rd(14, 8'h80, "R1 R11 status after reset");
    rd(13, 8'h00, "R1 control after reset");
    rd(15, 8'h00, "R1 int enable after reset");
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    for (int k = 0; k < 7; k++) rd(k, m_shd[k], "R1 time after reset");

    // R2 stopped: ticks ignored
    ticks(3);
    snap_check("R2 hold while stopped");
    rd(14, exp_stat(), "R2 status run bit low");

    // R3 R4 R5 R6: non-leap Feb 28 -> Mar 1, weekday 6 -> 0
    load_time(8'h58, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23);
    wr(6, 8'h06);
    wr(13, 8'h01);
    rd(14, exp_stat(), "R2 status run bit high");
    ticks(1);
    snap_check("R3 seconds step");
    ticks(1);
    snap_check("R3 R4 R6 non-leap February wrap");
    rd(14, exp_stat(), "R8 all events set");

    // R10 write-0 no effect, write-1 clears, bit1 untouched
    wr(14, 8'h00);
    rd(14, exp_stat(), "R10 zero write keeps flags");
    wr(14, 8'hFF);
    rd(14, exp_stat(), "R10 R11 W1C clears, run bit kept");

    // R4 leap February
    load_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24);
    ticks(1);
    snap_check("R4 leap Feb 29");
    load_time(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24);
    ticks(1);
    snap_check("R4 leap Feb 29 to Mar 1");

    // R4 30-day month
    load_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h10);
    ticks(1);
    snap_check("R4 April 30 wrap");

    // R5 year wrap
    load_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
    ticks(1);
    snap_check("R5 year 99 wrap");
    rd(14, exp_stat(), "R8 day event");

    // R7 shadow is stale until next capture; bit 6 self-clears
    wr(13, 8'h41);
    rd(13, 8'h41, "R7 capture bit visible one cycle");
    cyc(1'b0, 0, 8'h00, 1'b0);
    rd(13, m_ctrl, "R7 capture bit cleared");
    ticks(2);
    for (int k = 0; k < 7; k++) rd(k, m_shd[k], "R7 shadow unchanged after ticks");
    snap_check("R7 new capture");

    // R9 alarm
    wr(14, 8'hFC);
    load_time(8'h05, 8'h00, 8'h12, 8'h15, 8'h07, 8'h30);
    wr(7, 8'h07); wr(8, 8'h00); wr(9, 8'h12);
    wr(10, 8'h15); wr(11, 8'h07); wr(12, 8'h30);
    wr(15, 8'h08);
    ticks(1);
    rd(14, exp_stat(), "R9 no alarm before match");
    ticks(1);
    rd(14, exp_stat(), "R9 alarm flag on match");
    chk("R9 irq on alarm", {7'b0, irq}, 8'h01);
    wr(14, 8'h40);
    chk("R10 irq drops after clear", {7'b0, irq}, 8'h00);

    // R12 periodic selections
    wr(14, 8'hFC);
    wr(15, 8'h05);
    load_time(8'h58, 8'h10, 8'h01, 8'h02, 8'h03, 8'h04);
    ticks(1);
    chk("R12 minute select quiet", {7'b0, irq}, 8'h00);
    ticks(1);
    chk("R12 minute select fires", {7'b0, irq}, 8'h01);
    wr(14, 8'hFC);
    wr(15, 8'h04);
    ticks(1);
    chk("R12 second select fires", {7'b0, irq}, 8'h01);
    wr(15, 8'h07);
    chk("R12 day select quiet", {7'b0, irq}, 8'h00);
    rd(15, 8'h07, "R12 enable readback");

    // R13 readback and unmapped
    wr(16, 8'hA5); wr(17, 8'h3C);
    rd(16, 8'hA5, "R13 comp low");
    rd(17, 8'h3C, "R13 comp high");
    for (int k = 0; k < 6; k++) rd(7 + k, m_alm[k], "R13 alarm readback");
    rd(18, 8'h00, "R13 unmapped 0x12");
    rd(31, 8'h00, "R13 unmapped 0x1F");
    bus_addr = 5'd16;
    #1;
    chk("R13 read enable low", bus_rdata, 8'h00);

    // R2 stop again
    wr(13, 8'h00);
    ticks(2);
    snap_check("R2 stop freezes");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule